// File: doc/BRIEF.md
# Traffic Class To Virtual Channel Mapper

This block takes the 3-bit traffic class of an incoming packet and resolves it to a virtual channel identifier, using a mapping that software programs. Each channel resource has an enable bit, a 3-bit channel ID and an 8-bit bitmap of the traffic classes it carries. In the same pass the block decides whether the packet may be taken. A packet whose class maps to no resource, or whose class resolves to a resource that is switched off, is flagged as malformed so the surrounding logic can drop it.

Traffic class 0 always lands on channel 0, and resource 0 can never be disabled. Any number of classes may share a resource. If a class is set in the bitmaps of several resources, the lowest-numbered resource wins, even when that resource is disabled. The decision is registered, so the result for a packet presented in one cycle appears one cycle later. A build with a single channel resource skips the lookup and sends every class to channel 0.

Top module: `tcvc_mapper`

## Requirements
- R1: The result for a packet is presented exactly one clock after `in_valid` is sampled high. When `in_valid` was low, both strobes are low and `out_vc` is 0.
- R2: Traffic class 0 is accepted on channel ID 0 whatever the bitmaps, enables and IDs hold.
- R3: `out_accept` and `out_malformed` are never high together.
- R4: A nonzero class goes to the lowest resource index i with `tc_map[i*8 + tc]` set. If i > 0 and `ch_en[i]` is 1, the packet is accepted and `out_vc` equals `ch_id[i*3 +: 3]`.
- R5: A nonzero class that is set in no resource's bitmap is flagged malformed, with `out_vc` 0.
- R6: If the lowest matching resource has its enable bit at 0, the packet is flagged malformed, even when a higher resource that also matches is enabled. `out_vc` is then 0.
- R7: Resource 0 always counts as enabled and always carries channel ID 0. `ch_en[0]` and `ch_id[2:0]` have no effect on the result.
- R8: With `NUM_CH` = 1, every valid packet is accepted on channel 0 whatever its class and bitmap.
- R9: While `rst_n` is low, `out_accept`, `out_malformed` and `out_vc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A packet's class is presented this cycle |
| in_tc | input | 3 | Traffic class of the packet |
| ch_en | input | NUM_CH | Enable bit per channel resource (bit 0 ignored) |
| ch_id | input | NUM_CH*3 | Channel ID per resource, resource i at bits [i*3 +: 3] (resource 0 ignored) |
| tc_map | input | NUM_CH*8 | Class bitmap per resource, class t of resource i at bit i*8+t |
| out_vc | output | 3 | Selected channel ID, 0 unless accepted |
| out_accept | output | 1 | One-cycle strobe: packet accepted |
| out_malformed | output | 1 | One-cycle strobe: packet malformed, to be discarded |

## Verification
On every cycle the assertions check three things: the two strobes exclude each other, a strobe appears exactly when a packet was presented one cycle earlier, and class 0 always comes out accepted on channel 0. A malformed result always carries channel 0. The bench's programmed tables are the only way to show that the lowest resource wins an overlap, that a disabled winner is not replaced by an enabled higher match, that unmapped classes are rejected, and that the resource 0 enable and ID inputs have no effect. A second instance built with a single resource covers the variant that accepts every class on channel 0.

// File: rtl/tcvc_pkg.sv
package tcvc_pkg;
   localparam int TC_W    = 3;
   localparam int NUM_TC  = 1 << TC_W;
   localparam int VC_ID_W = 3;
   localparam int MAX_CH  = 1 << VC_ID_W;

   typedef struct packed {
      logic               accept;
      logic               malformed;
      logic [VC_ID_W-1:0] vc;
   } map_res_t;
endpackage

// File: rtl/tcvc_match.sv
// Per-resource hit vector for one traffic class.
module tcvc_match
   import tcvc_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic [TC_W-1:0]          tc,
   input  logic [NUM_CH*NUM_TC-1:0] tc_map,
   output logic [NUM_CH-1:0]        hit
);
   // resource 0 implicitly carries class 0
   assign hit[0] = (tc == '0) | tc_map[tc];

   for (genvar i = 1; i < NUM_CH; i++) begin : g_res
      assign hit[i] = tc_map[i*NUM_TC + int'(tc)];
   end
endmodule

// File: rtl/tcvc_prio.sv
// Lowest-index-wins encoder.
module tcvc_prio #(
   parameter int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             found
);
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tcvc_mapper.sv
module tcvc_mapper
   import tcvc_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [TC_W-1:0]           in_tc,
   input  logic [NUM_CH-1:0]         ch_en,
   input  logic [NUM_CH*VC_ID_W-1:0] ch_id,
   input  logic [NUM_CH*NUM_TC-1:0]  tc_map,
   output logic [VC_ID_W-1:0]        out_vc,
   output logic                      out_accept,
   output logic                      out_malformed
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("tcvc_mapper: NUM_CH must lie in 1..%0d", MAX_CH);
   end

   map_res_t nxt, res_q;

   if (NUM_CH == 1) begin : g_single
      // one resource: every class goes to channel 0
      logic unused_cfg;
      assign unused_cfg = ^{in_tc, ch_en, ch_id, tc_map};
      always_comb begin
         nxt        = '0;
         nxt.accept = in_valid;
      end
   end else begin : g_multi
      localparam int IDX_W = $clog2(NUM_CH);
      logic [NUM_CH-1:0] hit;
      logic [IDX_W-1:0]  win;
      logic              found;
      logic              win_on;
      logic              unused_cfg;

      // resource 0 enable and ID are fixed
      assign unused_cfg = ^{ch_en[0], ch_id[VC_ID_W-1:0]};

      tcvc_match #(.NUM_CH(NUM_CH)) u_match (
         .tc    (in_tc),
         .tc_map(tc_map),
         .hit   (hit)
      );

      tcvc_prio #(.N(NUM_CH)) u_prio (
         .req  (hit),
         .idx  (win),
         .found(found)
      );

      assign win_on = found && ((win == '0) || ch_en[win]);

      always_comb begin
         nxt = '0;
         if (in_valid) begin
            nxt.accept    = win_on;
            nxt.malformed = !win_on;
            if (win_on && win != '0)
               nxt.vc = ch_id[int'(win)*VC_ID_W +: VC_ID_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= nxt;
   end

   assign out_vc        = res_q.vc;
   assign out_accept    = res_q.accept;
   assign out_malformed = res_q.malformed;

   a_r3_excl_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_accept && out_malformed));

   a_r1_strobe_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_accept || out_malformed));

   a_r1_no_strobe_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !(out_accept || out_malformed));

   a_r2_tc0_on_vc0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_tc == '0) |=> (out_accept && out_vc == '0));

   a_r5_malformed_vc_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_malformed |-> (out_vc == '0));
endmodule

// File: tb/test_tcvc_mapper.sv
module test_tcvc_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_tc = '0;
   logic [7:0]  ch_en = '0;
   logic [23:0] ch_id = '0;
   logic [63:0] tc_map = '0;
   logic [7:0]  s_map = '0;
   logic [2:0]  s_id = '0;
   logic        s_en = 1'b0;

   logic [2:0] out_vc, s_vc;
   logic       out_accept, out_malformed, s_acc, s_mal;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tcvc_mapper #(.NUM_CH(8)) i_tcvc_mapper (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tc(in_tc),
      .ch_en(ch_en), .ch_id(ch_id), .tc_map(tc_map),
      .out_vc(out_vc), .out_accept(out_accept), .out_malformed(out_malformed));

   tcvc_mapper #(.NUM_CH(1)) i_tcvc_mapper_single (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tc(in_tc),
      .ch_en(s_en), .ch_id(s_id), .tc_map(s_map),
      .out_vc(s_vc), .out_accept(s_acc), .out_malformed(s_mal));

   // reference model: expected result one cycle after the sampled inputs
   logic [2:0] e_vc, es_vc;
   logic       e_acc, e_mal, es_acc;
   string      e_tag, es_tag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vc = 0; e_acc = 0; e_mal = 0; e_tag = "R9";
         es_vc = 0; es_acc = 0; es_tag = "R9";
      end else begin
         int win;
         win = -1;
         e_vc = 0; e_acc = 0; e_mal = 0;
         if (!in_valid) e_tag = "R1";
         else if (in_tc == 0) begin e_acc = 1; e_tag = "R2"; end
         else begin
            for (int i = 7; i >= 0; i--) if (tc_map[i*8 + in_tc]) win = i;
            if (win < 0) begin e_mal = 1; e_tag = "R5"; end
            else if (win == 0) begin e_acc = 1; e_tag = "R7"; end
            else if (!ch_en[win]) begin e_mal = 1; e_tag = "R6"; end
            else begin e_acc = 1; e_vc = ch_id[win*3 +: 3]; e_tag = "R4"; end
         end
         es_vc = 0; es_acc = in_valid; es_tag = in_valid ? "R8" : "R1";
      end
   end

   task automatic chk(string tag, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (!done) begin
      chk(e_tag, {out_accept, out_malformed, out_vc}, {e_acc, e_mal, e_vc}, "acc/mal/vc");
      chk(es_tag, {s_acc, s_mal, s_vc}, {es_acc, 1'b0, es_vc}, "single acc/mal/vc");
      chk("R3", int'(out_accept && out_malformed), 0, "both strobes");
   end

   task automatic send(bit v, int tc);
      @(negedge clk);
      in_valid = v;
      in_tc = 3'(tc);
   endtask

   task automatic set_res(int i, bit en, int id, int map);
      ch_en[i] = en;
      ch_id[i*3 +: 3] = 3'(id);
      tc_map[i*8 +: 8] = 8'(map);
   endtask

   initial begin
      in_valid = 1;
      in_tc = 3;
      tc_map = '1;
      ch_en = '1;
      repeat (3) @(negedge clk);            // R9 checked while held in reset
      ch_en = '0; tc_map = '0;
      rst_n = 1'b1;

      // classes 0-6 on resource 0, class 7 on resource 1 (R4, R2)
      set_res(0, 1, 0, 8'h7F);
      set_res(1, 1, 1, 8'h80);
      for (int t = 0; t < 8; t++) send(1, t);
      send(0, 5);                              // R1 idle
      send(0, 0);

      // four channels with arbitrary IDs
      set_res(0, 1, 0, 8'h03);
      set_res(1, 1, 5, 8'h1C);
      set_res(2, 1, 2, 8'h60);
      set_res(3, 1, 7, 8'h80);
      for (int t = 0; t < 8; t++) send(1, t);

      // R6: disabled winner, enabled higher match does not rescue
      set_res(2, 0, 2, 8'h60);
      set_res(4, 1, 4, 8'h20);
      send(1, 5); send(1, 6); send(1, 4);

      // R5: class 7 unmapped
      set_res(3, 1, 7, 8'h00);
      send(1, 7); send(1, 3);

      // R7: resource 0 enable and ID ignored, overlap lowest wins
      set_res(0, 0, 6, 8'h09);
      set_res(1, 1, 5, 8'h1C);
      send(1, 3); send(1, 0); send(1, 1); send(1, 4);

      // R2: class 0 with every bitmap cleared
      tc_map = '0; ch_en = '0;
      send(1, 0); send(1, 6);

      // randomized traffic and configuration
      for (int k = 0; k < 400; k++) begin
         if (k % 25 == 0) begin
            ch_en = 8'($urandom);
            ch_id = 24'($urandom);
            tc_map = {$urandom, $urandom} & {$urandom, $urandom};
            s_map = 8'($urandom); s_id = 3'($urandom); s_en = 1'($urandom);
         end
         send(1'($urandom), int'($urandom_range(0, 7)));
      end
      send(0, 0);
      @(negedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule